// File: doc/BRIEF.md
# Inter-Core Interrupt Signalling Registers

This block lets any of eight processor cores interrupt any other core and pass along a code that says who raised the interrupt. Each core owns a trigger register and a matching acknowledge register. A sender sets one or more source-code bits in the target core's trigger register. It can also pulse that core's interrupt line in the same write. The receiving core reads the codes from either register and writes ones to its acknowledge register to retire them. The interrupt outputs are single-cycle events meant for a downstream interrupt controller.

All writes to trigger and acknowledge registers are blocked until a core completes a two-key unlock: first key A, then key B, both with exact values and both from the same initiator. Any other key write locks the block again. Reads are always allowed.

Address map (word index on `busAddr`): 0 to 7 are the trigger registers of cores 0 to 7, 8 to 15 are the acknowledge registers of cores 0 to 7, 16 is key A and 17 is key B. Any other index reads 0. The default key values are 0x5A5A1234 (key A) and 0xC3D2E1F0 (key B).

Top module: `ipi_regs`

## Requirements
- R1: After reset every register reads 0, every interrupt output is low and the block is locked.
- R2: While locked, writes to trigger or acknowledge registers change no source bit and raise no interrupt.
- R3: Writing key A with its exact value and then key B with its exact value, from the same initiator, unlocks the block, after which trigger and acknowledge writes take effect.
- R4: Any key write that does not complete the sequence relocks the block. This covers a wrong value at either key, key B written without a preceding correct key A, and key A written again while unlocked.
- R5: If key B is written by a different initiator than the one that wrote key A, the block does not unlock.
- R6: A trigger-register write sets the source bits where data bits 31..4 are 1. Zeros in those positions leave bits unchanged, so codes accumulate.
- R7: A trigger-register write to core k with data bit 0 set drives `coreIrq[k]` high for exactly the one cycle after the write edge. No other core's line rises, and a write with bit 0 clear raises nothing.
- R8: Bits 3..0 of every read return 0. The acknowledge register of core k returns the same bits 31..4 as the trigger register of core k. The key registers read 0.
- R9: Writing 1 to an acknowledge bit clears that source bit in both views. Writing 0 has no effect.
- R10: Source bits of one core are unaffected by writes to another core's registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 5 | Register word index |
| busWdata | input | 32 | Write data |
| busWe | input | 1 | Write strobe, one access per cycle |
| busInitiator | input | 3 | Number of the core performing the access |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| coreIrq | output | 8 | One interrupt event line per core |

## Verification
The hardest states to reach are the near-miss unlock paths. These include key B arriving from a different initiator, a correct key B with no key A before it, and a correct key A rewritten while already unlocked. Each leaves the block locked, and that is visible only through a later write that fails to take effect. The stimulus walks through each of these sequences in turn. After every one it issues a trigger write with bit 0 set, then reads the register back and watches the interrupt lines. A stray unlock would show up as a changed code or an unexpected pulse.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int CORES   = 8;
  localparam int DATA_W  = 32;
  localparam int SRC_LSB = 4;
  localparam int SRC_W   = DATA_W - SRC_LSB;
  localparam int IDX_W   = $clog2(CORES);

  typedef enum logic [1:0] {
    LK_CLOSED,
    LK_HALF,
    LK_OPEN
  } lockState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic [CORES-1:0] genWr;
    logic [CORES-1:0] ackWr;
    logic             rdHit;
    logic [IDX_W-1:0] rdIdx;
  } regStrobe_t;
endpackage

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
  import ipi_pkg::*;
#(
  parameter int                ADDR_W = 5,
  parameter logic [DATA_W-1:0] KEY0   = 32'h5A5A_1234,
  parameter logic [DATA_W-1:0] KEY1   = 32'hC3D2_E1F0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWe,
  input  logic [IDX_W-1:0]  busInitiator,
  output regStrobe_t        strobe,
  output logic              wrOpen
);
  localparam int REG_W = ADDR_W - IDX_W;
  localparam logic [REG_W-1:0] RGN_GEN = REG_W'(0);
  localparam logic [REG_W-1:0] RGN_ACK = REG_W'(1);
  localparam logic [REG_W-1:0] RGN_KEY = REG_W'(2);

  logic [REG_W-1:0] region;
  logic [IDX_W-1:0] idx;
  logic             isKey0, isKey1;
  lockState_t       state, stateNext;
  logic [IDX_W-1:0] owner, ownerNext;
  logic [CORES-1:0] genWrV, ackWrV;

  assign region = busAddr[ADDR_W-1:IDX_W];
  assign idx    = busAddr[IDX_W-1:0];
  assign isKey0 = (region == RGN_KEY) && (idx == IDX_W'(0));
  assign isKey1 = (region == RGN_KEY) && (idx == IDX_W'(1));

  // two-key lock sequencer
  always_comb begin
    stateNext = state;
    ownerNext = owner;
    if (busWe && isKey0) begin
      if (busWdata == KEY0) begin
        stateNext = LK_HALF;
        ownerNext = busInitiator;
      end else begin
        stateNext = LK_CLOSED;
      end
    end else if (busWe && isKey1) begin
      if ((busWdata == KEY1) && (state == LK_HALF) && (busInitiator == owner)) begin
        stateNext = LK_OPEN;
      end else begin
        stateNext = LK_CLOSED;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= LK_CLOSED;
      owner <= '0;
    end else begin
      state <= stateNext;
      owner <= ownerNext;
    end
  end

  assign wrOpen = (state == LK_OPEN);

  generate
    for (genvar i = 0; i < CORES; i++) begin : g_dec
      assign genWrV[i] = busWe && wrOpen && (region == RGN_GEN) && (idx == IDX_W'(i));
      assign ackWrV[i] = busWe && wrOpen && (region == RGN_ACK) && (idx == IDX_W'(i));
    end
  endgenerate

  always_comb begin
    strobe.genWr = genWrV;
    strobe.ackWr = ackWrV;
    strobe.rdHit = (region == RGN_GEN) || (region == RGN_ACK);
    strobe.rdIdx = idx;
  end
endmodule

// File: rtl/ipi_datapath.sv
module ipi_datapath
  import ipi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [CORES-1:0]  coreIrq
);
  logic [SRC_W-1:0] srcBits [CORES];
  logic [SRC_W-1:0] wrSrc;
  logic             unusedWdata;

  assign wrSrc       = busWdata[DATA_W-1:SRC_LSB];
  assign unusedWdata = ^busWdata[SRC_LSB-1:1];

  generate
    for (genvar i = 0; i < CORES; i++) begin : g_core
      logic [SRC_W-1:0] setMask, clrMask;
      logic             irqQ;

      assign setMask = strobe.genWr[i] ? wrSrc : '0;
      assign clrMask = strobe.ackWr[i] ? wrSrc : '0;

      // set applied after clear: set wins on a collision
      always_ff @(posedge clk) begin
        if (!rstN) begin
          srcBits[i] <= '0;
          irqQ       <= 1'b0;
        end else begin
          srcBits[i] <= (srcBits[i] & ~clrMask) | setMask;
          irqQ       <= strobe.genWr[i] & busWdata[0];
        end
      end

      assign coreIrq[i] = irqQ;
    end
  endgenerate

  assign busRdata = strobe.rdHit ? {srcBits[strobe.rdIdx], {SRC_LSB{1'b0}}} : '0;
endmodule

// File: rtl/ipi_regs.sv
module ipi_regs
  import ipi_pkg::*;
#(
  parameter int                ADDR_W = 5,
  parameter logic [DATA_W-1:0] KEY0   = 32'h5A5A_1234,
  parameter logic [DATA_W-1:0] KEY1   = 32'hC3D2_E1F0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWe,
  input  logic [IDX_W-1:0]  busInitiator,
  output logic [DATA_W-1:0] busRdata,
  output logic [CORES-1:0]  coreIrq
);
  regStrobe_t strobe;
  logic       wrOpen;

  ipi_ctrl #(.ADDR_W(ADDR_W), .KEY0(KEY0), .KEY1(KEY1)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .busInitiator(busInitiator), .strobe(strobe), .wrOpen(wrOpen)
  );

  ipi_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .busRdata(busRdata), .coreIrq(coreIrq)
  );
endmodule

// File: rtl/ipi_regs_checker.sv
module ipi_regs_checker
  import ipi_pkg::*;
#(
  parameter int                ADDR_W = 5,
  parameter logic [DATA_W-1:0] KEY0   = 32'h5A5A_1234,
  parameter logic [DATA_W-1:0] KEY1   = 32'hC3D2_E1F0
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              busWe,
  input logic [DATA_W-1:0] busRdata,
  input logic [CORES-1:0]  coreIrq,
  input logic              wrOpen
);
  localparam logic [ADDR_W-1:0] K0A = ADDR_W'(2 << IDX_W);
  localparam logic [ADDR_W-1:0] K1A = ADDR_W'((2 << IDX_W) + 1);

  a_r7_single_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(coreIrq));

  a_r7_irq_has_cause: assert property (@(posedge clk) disable iff (!rstN)
    (|coreIrq) |-> $past(busWe && busWdata[0] && wrOpen));

  a_r2_locked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !wrOpen |=> (coreIrq == '0));

  a_r3_open_after_key1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrOpen) |-> $past(busWe && (busAddr == K1A) && (busWdata == KEY1)));

  a_r4_bad_key_relocks: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && (((busAddr == K0A) && (busWdata != KEY0)) ||
               ((busAddr == K1A) && (busWdata != KEY1)))) |=> !wrOpen);

  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[SRC_LSB-1:0] == '0);
endmodule

bind ipi_regs ipi_regs_checker #(.ADDR_W(ADDR_W), .KEY0(KEY0), .KEY1(KEY1)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata), .busWe(busWe),
  .busRdata(busRdata), .coreIrq(coreIrq), .wrOpen(wrOpen)
);

// File: tb/ipi_regs_bench.sv
module ipi_regs_bench;
  import ipi_pkg::*;
  localparam int          ADDR_W = 5;
  localparam logic [31:0] KA = 32'h5A5A_1234;
  localparam logic [31:0] KB = 32'hC3D2_E1F0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busWe = 1'b0;
  logic [2:0]  busInitiator = '0;
  logic [31:0] busRdata;
  logic [7:0]  coreIrq;

  ipi_regs #(.ADDR_W(ADDR_W), .KEY0(KA), .KEY1(KB)) u_ipi_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata), .busWe(busWe),
    .busInitiator(busInitiator), .busRdata(busRdata), .coreIrq(coreIrq)
  );

  always #2 clk = ~clk;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];

  int tests = 0;
  int fails = 0;
  logic [27:0] mSrc [8];
  int          mLock = 0;
  logic [2:0]  mOwner = '0;
  logic        rdActive = 1'b0;
  logic [7:0]  pendIrq = '0;
  logic [7:0]  expIrqNow = '0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] modelRead(input logic [4:0] a);
    if (a < 8)       return {mSrc[a[2:0]], 4'b0};
    else if (a < 16) return {mSrc[a[2:0]], 4'b0};
    else             return 32'h0;
  endfunction

  // driver: performs a write and updates the reference model
  task automatic busWrite(input logic [4:0] a, input logic [31:0] d, input logic [2:0] who);
    @(posedge clk); #1;
    busAddr = a; busWdata = d; busWe = 1'b1; busInitiator = who;
    if (a == 5'd16) begin
      if (d == KA) begin mLock = 1; mOwner = who; end
      else mLock = 0;
    end else if (a == 5'd17) begin
      mLock = (d == KB && mLock == 1 && who == mOwner) ? 2 : 0;
    end else if (mLock == 2 && a < 8) begin
      mSrc[a[2:0]] = mSrc[a[2:0]] | d[31:4];
      if (d[0]) pendIrq[a[2:0]] = 1'b1;
    end else if (mLock == 2 && a < 16) begin
      mSrc[a[2:0]] = mSrc[a[2:0]] & ~d[31:4];
    end
    @(posedge clk); #1;
    busWe = 1'b0;
  endtask

  // driver: issues a read and pushes the expected value to the scoreboard
  task automatic readCheck(input logic [4:0] a, input string tag);
    item_t it;
    @(posedge clk); #1;
    busAddr = a; busWe = 1'b0;
    it.exp = modelRead(a);
    it.tag = tag;
    sbq.push_back(it);
    rdActive = 1'b1;
    @(posedge clk); #1;
    rdActive = 1'b0;
  endtask

  always @(posedge clk) begin
    expIrqNow = pendIrq;
    pendIrq   = '0;
  end

  // monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (rdActive && sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        check(it.tag, busRdata, it.exp);
      end
      if (expIrqNow != 0 || coreIrq != 0)
        check("R7 irq pulse", {24'h0, coreIrq}, {24'h0, expIrqNow});
    end
  end

  task automatic unlock(input logic [2:0] who);
    busWrite(5'd16, KA, who);
    busWrite(5'd17, KB, who);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) mSrc[i] = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check("R1 irq after reset", {24'h0, coreIrq}, 32'h0);
    for (int a = 0; a < 18; a++) readCheck(5'(a), "R1 reset value");

    // R2: locked writes ignored
    busWrite(5'd2, 32'h0000_0021, 3'd0);
    readCheck(5'd2, "R2 locked trigger write");
    busWrite(5'd10, 32'hFFFF_FFF0, 3'd0);
    readCheck(5'd10, "R2 locked ack write");

    // R4: key B without key A
    busWrite(5'd17, KB, 3'd0);
    busWrite(5'd3, 32'h0000_0041, 3'd0);
    readCheck(5'd3, "R4 key B alone");
    // R4: wrong key B value after good key A
    busWrite(5'd16, KA, 3'd0);
    busWrite(5'd17, KB ^ 32'h1, 3'd0);
    busWrite(5'd3, 32'h0000_0041, 3'd0);
    readCheck(5'd3, "R4 wrong key B");

    // R5: initiator mismatch
    busWrite(5'd16, KA, 3'd1);
    busWrite(5'd17, KB, 3'd2);
    busWrite(5'd3, 32'h0000_0041, 3'd2);
    readCheck(5'd3, "R5 initiator mismatch");

    // R3: proper unlock
    unlock(3'd4);
    busWrite(5'd2, 32'h0000_0021, 3'd4);
    readCheck(5'd2, "R3 write after unlock");

    // R6: accumulate, zeros ignored
    busWrite(5'd2, 32'h0000_0100, 3'd4);
    readCheck(5'd2, "R6 accumulate");
    busWrite(5'd2, 32'h0000_0000, 3'd4);
    readCheck(5'd2, "R6 zero write no effect");

    // R8: mirror and reserved bits
    readCheck(5'd10, "R8 ack mirrors trigger");
    busWrite(5'd5, 32'h0000_00FE, 3'd4);
    readCheck(5'd5, "R8 reserved bits read 0");
    readCheck(5'd13, "R8 ack mirror core5");
    readCheck(5'd16, "R8 key reads 0");

    // R9: acknowledge clears both views
    busWrite(5'd10, 32'h0000_0020, 3'd4);
    readCheck(5'd2, "R9 ack clears trigger view");
    readCheck(5'd10, "R9 ack clears ack view");
    busWrite(5'd10, 32'h0000_0000, 3'd4);
    readCheck(5'd2, "R9 ack zero no effect");

    // R10 + R7: other cores untouched, irq on core 7
    busWrite(5'd7, 32'hFFFF_FFF1, 3'd4);
    readCheck(5'd7, "R10 core7 all codes");
    readCheck(5'd5, "R10 core5 unchanged");
    readCheck(5'd0, "R10 core0 unchanged");
    readCheck(5'd2, "R10 core2 unchanged");

    // R4: relock by wrong key A, then by rewriting key A while open
    busWrite(5'd16, 32'h0, 3'd4);
    busWrite(5'd0, 32'h0000_0011, 3'd4);
    readCheck(5'd0, "R4 wrong key A relocks");
    unlock(3'd6);
    busWrite(5'd16, KA, 3'd6);
    busWrite(5'd1, 32'h0000_0011, 3'd6);
    readCheck(5'd1, "R4 key A while open relocks");

    // R7: irq on core 0 after a fresh unlock
    unlock(3'd1);
    busWrite(5'd0, 32'h0000_0001, 3'd1);
    readCheck(5'd0, "R7 trigger only, no code");
    repeat (3) @(posedge clk);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule